// File: doc/BRIEF.md
# Interrupt Request and Poll Handshake

This block is the interrupt half of a direct-I/O peripheral. Three source flags feed it. The system flag is held inside the block: a set-interrupt strobe sets it and a clear strobe from control decode clears it. The limit-match flag and the lost-match (overflow) flag come from a neighbouring counter block.

The block does not store a request flip-flop. The request is derived from the source flags, gated by the interrupt enable and by an interrupt-active flip-flop. When the bus controller sends a poll-in strobe, the block answers one clock later. If a request is pending, it returns an acknowledge together with its device number. If nothing is pending, it returns a poll-out pass-through, so that the controller drops a request that has gone stale.

A reset-interrupt strobe ends the active state. The request is then evaluated again from whatever sources remain set. Mask-setting commands reach the block but have no effect, because the block has no mask.

Top module: `irq_poll_hs`

## Requirements
- R1: While reset is held and in the first cycle after it, irq_req, irq_ack, poll_out and irq_active are 0 and dev_data is all zeros.
- R2: irq_req equals (NOT active) AND (system flag OR (irq_en AND (limit_flag OR ovfl_flag))). The output is registered, so it shows the values the inputs and state had at the previous clock edge.
- R3: A set_int_stb sets the system flag. The request then rises even with irq_en at 0, provided that interrupt active is clear.
- R4: A sys_clr_stb clears the system flag. If set_int_stb and sys_clr_stb arrive in the same cycle, set_int_stb wins.
- R5: A poll_in_stb while a request is pending produces a one-cycle irq_ack in the following cycle, with dev_data equal to the DEV_NUM parameter (3 by default). In that same cycle irq_active is set and irq_req falls.
- R6: A poll_in_stb with no request pending produces a one-cycle poll_out in the following cycle, with irq_ack at 0 and dev_data at 0.
- R7: A reset_int_stb clears interrupt active, and irq_req returns in the next cycle if any source is still set. A poll_in_stb in the same cycle as reset_int_stb sees the active flip-flop already cleared.
- R8: While interrupt active is set, no source (a new counter match included) raises irq_req.
- R9: mask_cmd_stb has no effect on any output.
- R10: irq_ack and poll_out are never high together, and dev_data is non-zero only while irq_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_int_stb | input | 1 | Set-interrupt strobe (sets the system flag) |
| reset_int_stb | input | 1 | Reset-interrupt strobe (clears interrupt active) |
| poll_in_stb | input | 1 | Poll-in strobe from the bus controller |
| sys_clr_stb | input | 1 | Clear the system flag (from control decode) |
| mask_cmd_stb | input | 1 | Mask-setting command (ignored) |
| irq_en | input | 1 | Enable for counter-sourced interrupts |
| limit_flag | input | 1 | Limit-match flag from the counter |
| ovfl_flag | input | 1 | Lost-match flag from the counter |
| irq_req | output | 1 | Interrupt request to the bus controller |
| irq_ack | output | 1 | One-cycle acknowledge of a poll |
| poll_out | output | 1 | One-cycle poll pass-through |
| irq_active | output | 1 | Interrupt-active flip-flop |
| dev_data | output | DATA_W | Device number during acknowledge, 0 otherwise |

## Verification
The sharpest coincidences are a poll arriving in the same cycle as a reset-interrupt strobe, and a set-interrupt arriving in the same cycle as a flag clear. The bench drives each pair together on purpose. The first pair must give an acknowledge, because the active state counts as already cleared. The second pair must leave the system flag set. A behavioural model in the bench predicts every output on every clock, so the cycles around each collision are judged against the model as well as against literal expected values.

// File: rtl/ihs_pkg.sv
package ihs_pkg;
  // outcome of a poll-in strobe
  typedef enum logic [1:0] {
    POLL_IDLE = 2'd0,
    POLL_ACK  = 2'd1,
    POLL_PASS = 2'd2
  } poll_res_e;
endpackage

// File: rtl/ihs_src.sv
module ihs_src (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic en,
  input  logic lim,
  input  logic ovf,
  output logic sys_q,
  output logic sys_d,
  output logic src_now,
  output logic src_next
);
  logic cnt_src;

  always_comb begin
    cnt_src = en & (lim | ovf);
    sys_d   = sys_q;
    if (clr_stb) sys_d = 1'b0;
    if (set_stb) sys_d = 1'b1;
    src_now  = sys_q | cnt_src;
    src_next = sys_d | cnt_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_q <= 1'b0;
    else        sys_q <= sys_d;
  end

  // R3
  set_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> sys_q);
  // R4
  clr_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> !sys_q);
endmodule

// File: rtl/ihs_active.sv
module ihs_active (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_stb,
  input  logic grant,
  output logic active_q,
  output logic active_eff,
  output logic active_d
);
  always_comb begin
    active_eff = active_q & ~reset_stb;
    active_d   = active_eff | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  // R7
  reset_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_stb && !grant) |=> !active_q);
endmodule

// File: rtl/ihs_poll.sv
module ihs_poll #(
  parameter int DATA_W  = 16,
  parameter int DEV_NUM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_stb,
  input  logic              pending,
  output logic              ack,
  output logic              pass,
  output logic [DATA_W-1:0] data
);
  import ihs_pkg::*;
  localparam logic [DATA_W-1:0] DEV_WORD = DEV_NUM[DATA_W-1:0];

  poll_res_e res_d, res_q;

  always_comb begin
    res_d = POLL_IDLE;
    if (poll_stb) res_d = pending ? POLL_ACK : POLL_PASS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= POLL_IDLE;
    else        res_q <= res_d;
  end

  always_comb begin
    ack  = (res_q == POLL_ACK);
    pass = (res_q == POLL_PASS);
    data = ack ? DEV_WORD : '0;
  end

  // R10
  ack_pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && pass));
  // R5
  ack_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_stb && pending) |=> ack);
  // R6
  pass_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_stb && !pending) |=> pass);
endmodule

// File: rtl/irq_poll_hs.sv
module irq_poll_hs #(
  parameter int DATA_W  = 16,
  parameter int DEV_NUM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_int_stb,
  input  logic              reset_int_stb,
  input  logic              poll_in_stb,
  input  logic              sys_clr_stb,
  input  logic              mask_cmd_stb,
  input  logic              irq_en,
  input  logic              limit_flag,
  input  logic              ovfl_flag,
  output logic              irq_req,
  output logic              irq_ack,
  output logic              poll_out,
  output logic              irq_active,
  output logic [DATA_W-1:0] dev_data
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              irst_n;
  logic              sys_q, sys_d, src_now, src_next;
  logic              act_q, act_eff, act_d;
  logic              pending, grant, req_d, req_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign irst_n = rst_sync_q[SYNC_N-1];

  ihs_src u_src (
    .clk(clk), .rst_n(irst_n), .set_stb(set_int_stb), .clr_stb(sys_clr_stb),
    .en(irq_en), .lim(limit_flag), .ovf(ovfl_flag),
    .sys_q(sys_q), .sys_d(sys_d), .src_now(src_now), .src_next(src_next)
  );

  ihs_active u_act (
    .clk(clk), .rst_n(irst_n), .reset_stb(reset_int_stb), .grant(grant),
    .active_q(act_q), .active_eff(act_eff), .active_d(act_d)
  );

  always_comb begin
    pending = ~act_eff & src_now;
    grant   = poll_in_stb & pending;
    req_d   = ~act_d & src_next;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  ihs_poll #(.DATA_W(DATA_W), .DEV_NUM(DEV_NUM)) u_poll (
    .clk(clk), .rst_n(irst_n), .poll_stb(poll_in_stb), .pending(pending),
    .ack(irq_ack), .pass(poll_out), .data(dev_data)
  );

  assign irq_req    = req_q;
  assign irq_active = act_q;

  // R8
  no_req_active_chk: assert property (@(posedge clk) disable iff (!irst_n)
    irq_active |-> !irq_req);
  // R5
  ack_sets_active_chk: assert property (@(posedge clk) disable iff (!irst_n)
    irq_ack |-> irq_active);
  // R9
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (mask_cmd_stb && !set_int_stb && !reset_int_stb && !poll_in_stb)
      |=> $stable(irq_active));
  // R10
  data_only_ack_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (dev_data != '0) |-> irq_ack);
endmodule

// File: tb/irq_poll_hs_tb.sv
module irq_poll_hs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int DEV        = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_s = 0, rst_s = 0, poll_s = 0, clr_s = 0, mask_s = 0;
  logic en = 0, lim = 0, ovf = 0;
  logic req, ack, po, act;
  logic [DATA_W-1:0] data;

  int errors = 0;
  int checks = 0;
  string phase = "R1";
  bit run_cmp = 1'b0;

  // reference state
  bit m_sys, m_act, m_req, m_ack, m_po;
  int m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_poll_hs #(.DATA_W(DATA_W), .DEV_NUM(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_int_stb(set_s), .reset_int_stb(rst_s),
    .poll_in_stb(poll_s), .sys_clr_stb(clr_s), .mask_cmd_stb(mask_s),
    .irq_en(en), .limit_flag(lim), .ovfl_flag(ovf),
    .irq_req(req), .irq_ack(ack), .poll_out(po), .irq_active(act),
    .dev_data(data)
  );

  // behavioural model
  always @(posedge clk) begin
    bit eff, pend, src;
    if (!rst_n) begin
      m_sys = 0; m_act = 0; m_req = 0; m_ack = 0; m_po = 0; m_data = 0;
    end else begin
      eff  = m_act && !rst_s;
      src  = m_sys || (en && (lim || ovf));
      pend = !eff && src;
      m_ack  = poll_s && pend;
      m_po   = poll_s && !pend;
      m_data = m_ack ? DEV : 0;
      m_act  = eff || m_ack;
      if (clr_s) m_sys = 0;
      if (set_s) m_sys = 1;
      m_req = !m_act && (m_sys || (en && (lim || ovf)));
    end
  end

  task automatic chk(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(phase, "req",  int'(req),  int'(m_req));
      chk(phase, "ack",  int'(ack),  int'(m_ack));
      chk(phase, "pout", int'(po),   int'(m_po));
      chk(phase, "act",  int'(act),  int'(m_act));
      chk(phase, "data", int'(data), m_data);
    end
  end

  // drive after an edge, leaving the model's sample at that edge untouched
  task automatic step(bit s, bit r, bit p, bit c, bit m);
    @(posedge clk); #1;
    set_s = s; rst_s = r; poll_s = p; clr_s = c; mask_s = m;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  // sample at the negedge after the edge that consumed the last strobe
  task automatic settle();
    step(0, 0, 0, 0, 0);
    @(negedge clk); #1;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    // R1 reset state
    #(CLK_PERIOD * 3);
    chk("R1", "req", int'(req), 0);
    chk("R1", "data", int'(data), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    run_cmp = 1'b1;
    idle(2);

    // R2 counter sources with enable
    phase = "R2";
    @(posedge clk); #1; en = 1; lim = 1;
    settle(); chk("R2", "req lim", int'(req), 1);
    @(posedge clk); #1; lim = 0; ovf = 1;
    settle(); chk("R2", "req ovf", int'(req), 1);
    @(posedge clk); #1; en = 0;
    settle(); chk("R2", "req disabled", int'(req), 0);
    @(posedge clk); #1; ovf = 0;

    // R3 set-int without enable
    phase = "R3";
    step(1, 0, 0, 0, 0);
    settle(); chk("R3", "req", int'(req), 1);

    // R5 poll with pending
    phase = "R5";
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R5", "ack", int'(ack), 1);
    chk("R5", "data", int'(data), DEV);
    chk("R5", "req", int'(req), 0);
    idle(1);

    // R8 match while active
    phase = "R8";
    @(posedge clk); #1; en = 1; lim = 1;
    idle(3); @(negedge clk); #1;
    chk("R8", "req", int'(req), 0);

    // R9 mask command ignored
    phase = "R9";
    step(0, 0, 0, 0, 1);
    settle(); chk("R9", "act", int'(act), 1);
    chk("R9", "req", int'(req), 0);

    // R7 reset-int re-raises request
    phase = "R7";
    step(0, 1, 0, 0, 0);
    settle(); chk("R7", "req", int'(req), 1);
    chk("R7", "act", int'(act), 0);

    // R6 poll with nothing pending
    phase = "R6";
    @(posedge clk); #1; lim = 0; en = 0;
    step(0, 0, 0, 1, 0);
    idle(2);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R6", "pout", int'(po), 1);
    chk("R6", "ack", int'(ack), 0);
    idle(2);

    // R4 set and clear together: set wins
    phase = "R4";
    step(1, 0, 0, 1, 0);
    settle(); chk("R4", "req", int'(req), 1);
    step(0, 0, 0, 1, 0);
    settle(); chk("R4", "req cleared", int'(req), 0);

    // R7 reset-int and poll together, source still set
    phase = "R7";
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);   // grant, active set
    idle(2);
    step(0, 1, 1, 0, 0);   // same-cycle reset and poll
    step(0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R7", "ack coincident", int'(ack), 1);
    chk("R10", "pout", int'(po), 0);
    idle(2);

    // R10 poll while active: pass-through only
    phase = "R10";
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R10", "data", int'(data), 0);
    idle(3);

    run_cmp = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule